// File: doc/BRIEF.md
# Transmit Software Flow-Control Command Unit

This block sits between a host command strobe and the load port of a UART transmit shift register. It reads a 5-bit command code and handles software (Xon/Xoff) flow control on the transmit side. It can put one flow-control character ahead of the queued data. It can hold back data on a host stop command and release it on a resume command. It can also take back a control character that has not yet reached the shift register. It selects every byte presented to the shift register, from one of two sources: the Xon or Xoff character register, or the head of the transmit FIFO.

A load takes place in any cycle where the shift register reports that it is ready and there is something eligible to send. The load is combinational from registered state, so the byte is handed over in the same cycle that the ready signal is seen. Commands are captured on the clock edge. Their effect is visible from the following cycle.

Top module: `tx_flow_cmd`

## Requirements
- R1: Code 5'b10000 queues the Xon character and code 5'b10001 queues the Xoff character. At the next load, `shreg_data` carries that character and `txq_pop` stays low.
- R2: A queued control character is loaded before any FIFO byte. It is sent even while the host stop is in force.
- R3: At most one control character is queued. A new Xon/Xoff request replaces one that is still waiting.
- R4: Host stop (code 5'b10111) prevents any FIFO byte from being loaded in the cycles after the command is captured. A byte loaded in the same cycle as the command is not affected.
- R5: Resume (code 5'b10110) ends the host stop, and the next FIFO byte is loaded at the next opportunity.
- R6: Resume has no effect while `auto_mode` is 1.
- R7: Cancel (code 5'b11000) removes a queued control character that has not been loaded. If the character is loaded in the same cycle as the cancel, it is still sent. With nothing queued, cancel has no effect.
- R8: Code 5'b00000 and every code not named in R1, R4, R5, R7 or R9 leave the queued character and the stop state unchanged.
- R9: Reset-transmitter (code 5'b00011) clears both the queued control character and the host stop.
- R10: `shreg_load` is asserted only while `shreg_ready` is 1. `txq_pop` is asserted exactly for loads sourced from the FIFO.
- R11: After reset nothing is queued and the host stop is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_stb | input | 1 | Command valid for one cycle |
| cmd_code | input | 5 | Command code |
| xon_char | input | DATA_W | Xon character value |
| xoff_char | input | DATA_W | Xoff character value |
| auto_mode | input | 1 | Automatic transmit flow-control mode active |
| txq_nonempty | input | 1 | Transmit FIFO holds at least one byte |
| txq_data | input | DATA_W | Byte at the FIFO head |
| txq_pop | output | 1 | Remove the FIFO head (loaded this cycle) |
| shreg_ready | input | 1 | Shift register can accept a byte |
| shreg_load | output | 1 | Byte handed to shift register this cycle |
| shreg_data | output | DATA_W | Byte handed to shift register |

## Verification
The bench targets several ordering cases:
- An Xon request while FIFO data waits. A design that got this wrong would send a data byte first.
- Two requests back to back. A design that got this wrong would send both characters instead of only the later one.
- A control request made while data is held by a host stop. A design that blocked it would never send the character.
- A cancel that lands in the same cycle the character is loaded. A design that got this wrong would lose the character or report it twice.

It also checks resume under automatic mode, reserved and no-operation codes, and the reset-transmitter command. Wrong behaviour there would show up as FIFO bytes leaving early, or a stale control character being sent after it should have been cleared.

// File: rtl/tx_flow_cmd.sv
module tx_flow_cmd #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_stb,
  input  logic [4:0]        cmd_code,
  input  logic [DATA_W-1:0] xon_char,
  input  logic [DATA_W-1:0] xoff_char,
  input  logic              auto_mode,
  input  logic              txq_nonempty,
  input  logic [DATA_W-1:0] txq_data,
  output logic              txq_pop,
  input  logic              shreg_ready,
  output logic              shreg_load,
  output logic [DATA_W-1:0] shreg_data
);
  localparam logic [4:0] OP_RST_TX = 5'b00011;
  localparam logic [4:0] OP_XON    = 5'b10000;
  localparam logic [4:0] OP_XOFF   = 5'b10001;
  localparam logic [4:0] OP_RESUME = 5'b10110;
  localparam logic [4:0] OP_STOP   = 5'b10111;
  localparam logic [4:0] OP_CANCEL = 5'b11000;

  logic pend_q, pend_xoff_q, hold_q;

  wire ctrl_go = shreg_ready && pend_q;
  wire data_go = shreg_ready && !pend_q && txq_nonempty && !hold_q;

  assign shreg_load = ctrl_go || data_go;
  assign txq_pop    = data_go;
  assign shreg_data = pend_q ? (pend_xoff_q ? xoff_char : xon_char) : txq_data;

  wire is_cmd = cmd_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_xoff_q <= 1'b0;
      hold_q      <= 1'b0;
    end else begin
      if (is_cmd && cmd_code == OP_RST_TX) begin
        pend_q <= 1'b0;
      end else if (is_cmd && (cmd_code == OP_XON || cmd_code == OP_XOFF)) begin
        pend_q      <= 1'b1;
        pend_xoff_q <= (cmd_code == OP_XOFF);
      end else if ((is_cmd && cmd_code == OP_CANCEL) || ctrl_go) begin
        pend_q <= 1'b0;
      end

      if (is_cmd && cmd_code == OP_RST_TX)
        hold_q <= 1'b0;
      else if (is_cmd && cmd_code == OP_STOP)
        hold_q <= 1'b1;
      else if (is_cmd && cmd_code == OP_RESUME && !auto_mode)
        hold_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_flow_cmd_chk.sv
module tx_flow_cmd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_stb,
  input logic [4:0] cmd_code,
  input logic       auto_mode,
  input logic       txq_pop,
  input logic       shreg_ready,
  input logic       shreg_load,
  input logic       pend_q,
  input logic       pend_xoff_q,
  input logic       hold_q
);
  wire known = cmd_code == 5'b00011 || cmd_code == 5'b10000 || cmd_code == 5'b10001 ||
               cmd_code == 5'b10110 || cmd_code == 5'b10111 || cmd_code == 5'b11000;

  assert_load_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    shreg_load |-> shreg_ready);
  assert_pop_is_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    txq_pop |-> shreg_load);
  assert_held_no_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> !txq_pop);
  assert_ctrl_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && shreg_ready) |-> (shreg_load && !txq_pop));
  assert_xon_queued_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && cmd_code == 5'b10000) |=> (pend_q && !pend_xoff_q));
  assert_xoff_queued_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && cmd_code == 5'b10001) |=> (pend_q && pend_xoff_q));
  assert_resume_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && cmd_code == 5'b10110 && !auto_mode) |=> !hold_q);
  assert_auto_resume_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && cmd_code == 5'b10110 && auto_mode && hold_q) |=> hold_q);
  assert_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && cmd_code == 5'b11000) |=> !pend_q);
  assert_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && !known && !shreg_load) |=> ($stable(pend_q) && $stable(hold_q)));
  assert_reset_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && cmd_code == 5'b00011) |=> (!pend_q && !hold_q));
endmodule

bind tx_flow_cmd tx_flow_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
  .auto_mode(auto_mode), .txq_pop(txq_pop), .shreg_ready(shreg_ready),
  .shreg_load(shreg_load), .pend_q(pend_q), .pend_xoff_q(pend_xoff_q),
  .hold_q(hold_q)
);

// File: tb/test_tx_flow_cmd.sv
module test_tx_flow_cmd;
  localparam logic [7:0] XON_C  = 8'h11;
  localparam logic [7:0] XOFF_C = 8'h13;

  logic clk = 0, rst_n = 0;
  logic cmd_stb = 0;
  logic [4:0] cmd_code = 0;
  logic auto_mode = 0, shreg_ready = 0;
  logic txq_pop, shreg_load;
  logic [7:0] shreg_data;
  logic [7:0] fq[$];
  logic [8:0] exp_q[$];
  logic txq_nonempty;
  logic [7:0] txq_data;
  int checks = 0, failures = 0;
  bit done = 0;

  assign txq_nonempty = fq.size() != 0;
  assign txq_data = (fq.size() != 0) ? fq[0] : 8'h00;

  always #4 clk = ~clk;

  tx_flow_cmd i_tx_flow_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
    .xon_char(XON_C), .xoff_char(XOFF_C), .auto_mode(auto_mode),
    .txq_nonempty(txq_nonempty), .txq_data(txq_data), .txq_pop(txq_pop),
    .shreg_ready(shreg_ready), .shreg_load(shreg_load), .shreg_data(shreg_data)
  );

  // monitor: samples on falling edge, away from the active edge
  always @(negedge clk) begin
    if (rst_n && shreg_load) begin
      logic [8:0] e;
      checks++;
      if (!shreg_ready) begin
        failures++;
        $display("FAIL R10 load without ready: got %h/%0b expected no load", shreg_data, txq_pop);
      end else if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R4/R8 unexpected load: got %h pop=%0b expected none", shreg_data, txq_pop);
      end else begin
        e = exp_q.pop_front();
        if ({txq_pop, shreg_data} !== e) begin
          failures++;
          $display("FAIL R1/R2/R3/R5/R7/R9/R10 load: got pop=%0b data=%h expected pop=%0b data=%h",
                   txq_pop, shreg_data, e[8], e[7:0]);
        end
      end
      if (txq_pop && fq.size() != 0) void'(fq.pop_front());
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cmd(logic [4:0] c);
    cmd_stb = 1; cmd_code = c;
    step(1);
    cmd_stb = 0; cmd_code = 0;
  endtask

  task automatic expect_ctrl(logic [7:0] b);
    exp_q.push_back({1'b0, b});
  endtask

  task automatic push_data(logic [7:0] b);
    fq.push_back(b);
    exp_q.push_back({1'b1, b});
  endtask

  task automatic drained(string tag);
    step(6);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL %s missing loads: got %0d outstanding expected 0", tag, exp_q.size());
      exp_q.delete();
    end
  endtask

  task automatic held_check(string tag);
    step(5);
    checks++;
    if (fq.size() == 0) begin
      failures++;
      $display("FAIL %s data left while held: got fifo=0 expected nonzero", tag);
    end
  endtask

  initial begin
    step(3);
    checks++;
    if (shreg_load !== 1'b0 || txq_pop !== 1'b0) begin
      failures++;
      $display("FAIL R11 reset outputs: got load=%0b pop=%0b expected 0 0", shreg_load, txq_pop);
    end
    rst_n = 1;
    step(2);
    // R11: not held after reset, data flows
    push_data(8'hA0);
    shreg_ready = 1;
    drained("R11");

    // R1 R2: Xon ahead of queued data
    shreg_ready = 0;
    push_data(8'hA1); push_data(8'hA2);
    exp_q.push_front({1'b0, XON_C});
    cmd(5'b10000);
    shreg_ready = 1;
    drained("R1_R2");

    // R3: later request replaces earlier
    shreg_ready = 0;
    cmd(5'b10000); cmd(5'b10001);
    expect_ctrl(XOFF_C);
    push_data(8'hB1);
    shreg_ready = 1;
    drained("R3");

    // R4: host stop holds data; R2: ctrl still goes; R5 resume
    shreg_ready = 0;
    cmd(5'b10111);
    fq.push_back(8'hC1); fq.push_back(8'hC2);
    shreg_ready = 1;
    held_check("R4");
    expect_ctrl(XON_C);
    cmd(5'b10000);
    drained("R2_held");
    exp_q.push_back({1'b1, 8'hC1}); exp_q.push_back({1'b1, 8'hC2});
    cmd(5'b10110);
    drained("R5");

    // R6: resume ignored in auto mode
    shreg_ready = 0;
    auto_mode = 1;
    cmd(5'b10111); cmd(5'b10110);
    fq.push_back(8'hD1);
    shreg_ready = 1;
    held_check("R6");
    auto_mode = 0;
    exp_q.push_back({1'b1, 8'hD1});
    cmd(5'b10110);
    drained("R6_release");

    // R7: cancel before load
    shreg_ready = 0;
    cmd(5'b10001); cmd(5'b11000);
    push_data(8'hE1);
    shreg_ready = 1;
    drained("R7_cancel");
    // R7: cancel with nothing pending
    shreg_ready = 0;
    cmd(5'b11000);
    push_data(8'hE2);
    shreg_ready = 1;
    drained("R7_empty");
    // R7: cancel in the load cycle does not withdraw
    expect_ctrl(XON_C);
    cmd(5'b10000); cmd(5'b11000);
    drained("R7_late");

    // R8: no-op and reserved codes
    shreg_ready = 0;
    cmd(5'b10000);
    cmd(5'b00000); cmd(5'b00001); cmd(5'b11001); cmd(5'b11111); cmd(5'b00010);
    expect_ctrl(XON_C);
    shreg_ready = 1;
    drained("R8_pend");
    cmd(5'b10111);
    cmd(5'b11010); cmd(5'b01011);
    fq.push_back(8'hF1);
    held_check("R8_hold");
    exp_q.push_back({1'b1, 8'hF1});
    cmd(5'b10110);
    drained("R8_release");

    // R9: reset-transmitter clears both
    shreg_ready = 0;
    cmd(5'b10111); cmd(5'b10001); cmd(5'b00011);
    push_data(8'h5A);
    shreg_ready = 1;
    drained("R9");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule